// File: doc/BRIEF.md
# DRAM Read Burst Latency Sequencer

This block models, one clock at a time, the read data path of a double-data-rate SDRAM device. A READ request carries a bank, a column, an auto-precharge flag and a burst mode, either eight beats or a chopped four. The sequencer waits out the read latency, which is the sum of two separately programmed values: an additive latency and a CAS latency. It then drives two data beats per clock, one for the rising half and one for the falling half. It also produces the strobe framing flags (drive enable, preamble, postamble) and a data-drive flag that stands for the bus leaving high impedance.

Requests must be spaced at least four clocks apart. A request that arrives too early is dropped and flagged for one cycle. Two eight-beat reads at exactly that spacing form one gapless stream. Two chopped reads at that spacing leave a two-clock hole between them. When auto-precharge was requested, a one-cycle precharge request that names the bank follows the last data clock. Beat data comes from a fixed function of bank and column, so every beat can be predicted.

Top module: `ddr_rd_seq`

## Requirements
- R1: While reset is held, every output is 0.
- R2: A READ in cycle c that is accepted puts its first beat pair on the outputs in cycle c+AL+CL (CL 5..11, AL 0..CL-1). In burst clock k, the rising half carries beat 2k and the falling half carries beat 2k+1. Beat i uses the column whose upper bits [9:3] are those of the request and whose low three bits are (col[2:0]+i) mod 8.
- R3: Each beat word is 16 bits, formed as {3'b101, bank[2:0], beat column[9:0]} with the tag in the top bits.
- R4: An eight-beat read (chop=0) occupies 4 consecutive data clocks. A chopped read (chop=1) occupies 2 data clocks and carries the first four beats of the same order.
- R5: dq_oe is 1 exactly in the clocks that carry data and 0 otherwise (bus released).
- R6: dqs_pre is 1 in the clock just before a data clock that follows a clock without data. In that clock dq_oe is 0.
- R7: dqs_post is 1 in the final data clock of a burst when the next clock carries no data.
- R8: A READ accepted exactly 4 clocks after the previous one continues the data stream with no idle clock and with no postamble or preamble between the bursts.
- R9: Two chopped reads spaced 4 clocks apart leave a 2-clock gap. That gap is framed by a postamble at its start and a preamble in its last clock.
- R10: A READ arriving fewer than 4 clocks after the last accepted READ produces no data. It raises spacing_err for exactly the one cycle after it.
- R11: If ap=1, pre_req pulses for one cycle in the clock after the last data clock, with pre_bank equal to the request's bank. If ap=0, no pulse follows.
- R12: dqs_oe equals dq_oe OR dqs_pre.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_rd | input | 1 | READ request strobe |
| cmd_bank | input | 3 | Bank address |
| cmd_col | input | 10 | Starting column |
| cmd_ap | input | 1 | Auto-precharge after the burst |
| cmd_chop | input | 1 | 1 = chopped four-beat burst |
| cfg_cl | input | 4 | CAS latency |
| cfg_al | input | 4 | Additive latency |
| dq_rise | output | 16 | Beat on the rising half |
| dq_fall | output | 16 | Beat on the falling half |
| dq_oe | output | 1 | Data bus driven |
| dqs_oe | output | 1 | Strobe driven |
| dqs_pre | output | 1 | Read preamble clock |
| dqs_post | output | 1 | Read postamble clock |
| spacing_err | output | 1 | Request dropped for short spacing |
| pre_req | output | 1 | End-of-burst precharge request |
| pre_bank | output | 3 | Bank named by pre_req |

## Verification
For a request driven in cycle c, data is due in cycles c+AL+CL through c+AL+CL+3, or through c+AL+CL+1 for a chopped read. The preamble is due one cycle before the data, the precharge request one cycle after the last data clock, and spacing_err in cycle c+1. The bench stores each expected value in a per-cycle table at the moment it issues the request. Every cycle it compares the outputs against that table, half a clock after the edge that updates them. The preamble and postamble expectations are derived from the table's data occupancy of the current cycle and the next cycle.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;
  localparam int BANK_W = 3;
  localparam int COL_W  = 10;
  localparam int LAT_W  = 4;
  localparam int TAG_W  = 3;
  localparam logic [TAG_W-1:0] BEAT_TAG = 3'b101;
  localparam int WORD_W = TAG_W + BANK_W + COL_W;

  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [COL_W-1:0]  col_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LAT_W-1:0]  lat_t;

  // column of beat idx: wraps inside the aligned group of eight
  function automatic col_t beat_col(col_t c, logic [2:0] idx);
    logic [2:0] lo;
    lo = c[2:0] + idx;
    return {c[COL_W-1:3], lo};
  endfunction

  function automatic word_t beat_word(bank_t b, col_t c, logic [2:0] idx);
    return {BEAT_TAG, b, beat_col(c, idx)};
  endfunction

  // data clocks per burst: two beats per clock
  function automatic logic [2:0] burst_clks(logic chop);
    return chop ? 3'd2 : 3'd4;
  endfunction

  function automatic logic [LAT_W:0] read_lat(lat_t al, lat_t cl);
    return {1'b0, al} + {1'b0, cl};
  endfunction
endpackage

// File: rtl/rd_gap.sv
module rd_gap #(
  parameter int TCCD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_rd,
  output logic accept,
  output logic err
);
  localparam int CW = $clog2(TCCD + 1);
  localparam logic [CW-1:0] FULL = CW'(TCCD);

  logic [CW-1:0] since;

  assign accept = cmd_rd && (since == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= FULL;
      err   <= 1'b0;
    end else begin
      err <= cmd_rd && !accept;
      if (accept)
        since <= CW'(1);
      else if (since != FULL)
        since <= since + CW'(1);
    end
  end
endmodule

// File: rtl/rd_slot.sv
module rd_slot
  import ddr_rd_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] ld_start,
  input  bank_t         ld_bank,
  input  col_t          ld_col,
  input  logic          ld_ap,
  input  logic          ld_chop,
  input  logic [TW-1:0] nxt,
  output logic          busy,
  output logic          act,
  output logic          last,
  output logic          pend1,
  output logic          done_ap,
  output bank_t         bank,
  output word_t         rise_w,
  output word_t         fall_w
);
  logic          vld;
  logic [TW-1:0] start;
  col_t          col_q;
  logic          ap_q;
  logic          chop_q;
  logic [TW-1:0] behind;
  logic [TW-1:0] ahead;
  logic [TW-1:0] len;
  logic          done;

  always_comb begin
    behind  = nxt - start;
    ahead   = start - nxt;
    len     = TW'(burst_clks(chop_q));
    act     = vld && (behind < len);
    last    = act && (behind == len - TW'(1));
    done    = vld && (behind == len);
    pend1   = vld && (ahead == TW'(1));
    done_ap = done && ap_q;
    busy    = vld;
    rise_w  = act ? beat_word(bank, col_q, {behind[1:0], 1'b0}) : '0;
    fall_w  = act ? beat_word(bank, col_q, {behind[1:0], 1'b1}) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= 1'b0;
      start  <= '0;
      bank   <= '0;
      col_q  <= '0;
      ap_q   <= 1'b0;
      chop_q <= 1'b0;
    end else if (load) begin
      vld    <= 1'b1;
      start  <= ld_start;
      bank   <= ld_bank;
      col_q  <= ld_col;
      ap_q   <= ld_ap;
      chop_q <= ld_chop;
    end else if (done) begin
      vld <= 1'b0;
    end
  end
endmodule

// File: rtl/rd_frame.sv
module rd_frame
  import ddr_rd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  act_any,
  input  logic  last_any,
  input  logic  pend_any,
  input  logic  dap_any,
  input  bank_t dap_bank,
  input  word_t rise_or,
  input  word_t fall_or,
  output word_t dq_rise,
  output word_t dq_fall,
  output logic  dq_oe,
  output logic  dqs_oe,
  output logic  dqs_pre,
  output logic  dqs_post,
  output logic  pre_req,
  output bank_t pre_bank
);
  logic pre_nxt;
  assign pre_nxt = pend_any && !act_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_rise  <= '0;
      dq_fall  <= '0;
      dq_oe    <= 1'b0;
      dqs_oe   <= 1'b0;
      dqs_pre  <= 1'b0;
      dqs_post <= 1'b0;
      pre_req  <= 1'b0;
      pre_bank <= '0;
    end else begin
      dq_rise  <= rise_or;
      dq_fall  <= fall_or;
      dq_oe    <= act_any;
      dqs_oe   <= act_any || pre_nxt;
      dqs_pre  <= pre_nxt;
      dqs_post <= last_any && !pend_any;
      pre_req  <= dap_any;
      pre_bank <= dap_bank;
    end
  end
endmodule

// File: rtl/ddr_rd_seq.sv
module ddr_rd_seq
  import ddr_rd_pkg::*;
#(
  parameter int CL_MAX = 11,
  parameter int TCCD   = 4,
  parameter int TW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_rd,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [COL_W-1:0]     cmd_col,
  input  logic                 cmd_ap,
  input  logic                 cmd_chop,
  input  logic [LAT_W-1:0]     cfg_cl,
  input  logic [LAT_W-1:0]     cfg_al,
  output logic [WORD_W-1:0]    dq_rise,
  output logic [WORD_W-1:0]    dq_fall,
  output logic                 dq_oe,
  output logic                 dqs_oe,
  output logic                 dqs_pre,
  output logic                 dqs_post,
  output logic                 spacing_err,
  output logic                 pre_req,
  output logic [BANK_W-1:0]    pre_bank
);
  localparam int RL_MAX = 2 * CL_MAX - 1;
  localparam int LIFE   = RL_MAX + 4 + 1;
  localparam int NSLOT  = (LIFE + TCCD - 1) / TCCD;
  localparam int PW     = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic          accept;
  logic [TW-1:0] now;
  logic [TW-1:0] nxt;
  logic [TW-1:0] ld_start;
  logic [PW-1:0] wr_ptr;

  logic [NSLOT-1:0] act_vec, last_vec, pend_vec, dap_vec, busy_vec;
  bank_t slot_bank [NSLOT];
  word_t slot_rise [NSLOT];
  word_t slot_fall [NSLOT];

  logic  act_any, last_any, pend_any, dap_any;
  bank_t dap_bank;
  word_t rise_or, fall_or;
  logic  load_clash;

  rd_gap #(.TCCD(TCCD)) u_gap (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd),
    .accept(accept), .err(spacing_err)
  );

  assign nxt      = now + TW'(1);
  assign ld_start = now + TW'(read_lat(cfg_al, cfg_cl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now    <= '0;
      wr_ptr <= '0;
    end else begin
      now <= nxt;
      if (accept)
        wr_ptr <= (wr_ptr == PW'(NSLOT - 1)) ? '0 : wr_ptr + PW'(1);
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    rd_slot #(.TW(TW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .load(accept && (wr_ptr == PW'(s))),
      .ld_start(ld_start), .ld_bank(cmd_bank), .ld_col(cmd_col),
      .ld_ap(cmd_ap), .ld_chop(cmd_chop), .nxt(nxt),
      .busy(busy_vec[s]), .act(act_vec[s]), .last(last_vec[s]),
      .pend1(pend_vec[s]), .done_ap(dap_vec[s]), .bank(slot_bank[s]),
      .rise_w(slot_rise[s]), .fall_w(slot_fall[s])
    );
  end

  always_comb begin
    rise_or  = '0;
    fall_or  = '0;
    dap_bank = '0;
    for (int s = 0; s < NSLOT; s++) begin
      rise_or  = rise_or | slot_rise[s];
      fall_or  = fall_or | slot_fall[s];
      dap_bank = dap_bank | (dap_vec[s] ? slot_bank[s] : '0);
    end
    act_any    = |act_vec;
    last_any   = |last_vec;
    pend_any   = |pend_vec;
    dap_any    = |dap_vec;
    load_clash = accept && busy_vec[wr_ptr];
  end

  rd_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .act_any(act_any), .last_any(last_any), .pend_any(pend_any),
    .dap_any(dap_any), .dap_bank(dap_bank),
    .rise_or(rise_or), .fall_or(fall_or),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_oe(dq_oe), .dqs_oe(dqs_oe),
    .dqs_pre(dqs_pre), .dqs_post(dqs_post),
    .pre_req(pre_req), .pre_bank(pre_bank)
  );
endmodule

// File: rtl/rd_seq_chk.sv
module rd_seq_chk #(
  parameter int N = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_rd,
  input logic         dq_oe,
  input logic         dqs_oe,
  input logic         dqs_pre,
  input logic         dqs_post,
  input logic         spacing_err,
  input logic         pre_req,
  input logic [N-1:0] act_vec,
  input logic         load_clash
);
  // R12
  strobe_covers_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> dqs_oe);
  // R6
  preamble_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_pre |-> !dq_oe);
  // R6
  preamble_leads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_pre |=> dq_oe);
  // R7
  postamble_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_post |-> dq_oe);
  // R7
  postamble_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_post |=> !dq_oe);
  // R10
  spacing_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spacing_err |-> $past(cmd_rd));
  // R11
  precharge_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_req |-> $past(dq_oe));
  // R5
  single_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_vec));
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_clash);
endmodule

bind ddr_rd_seq rd_seq_chk #(.N(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .dq_oe(dq_oe), .dqs_oe(dqs_oe),
  .dqs_pre(dqs_pre), .dqs_post(dqs_post), .spacing_err(spacing_err),
  .pre_req(pre_req), .act_vec(act_vec), .load_clash(load_clash)
);

// File: tb/tb_ddr_rd_seq.sv
module tb_ddr_rd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_rd = 1'b0;
  logic [2:0]  cmd_bank = '0;
  logic [9:0]  cmd_col = '0;
  logic        cmd_ap = 1'b0;
  logic        cmd_chop = 1'b0;
  logic [3:0]  cfg_cl = 4'd5;
  logic [3:0]  cfg_al = 4'd0;
  logic [15:0] dq_rise, dq_fall;
  logic        dq_oe, dqs_oe, dqs_pre, dqs_post, spacing_err, pre_req;
  logic [2:0]  pre_bank;

  always #10 clk = ~clk;

  ddr_rd_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_bank(cmd_bank),
    .cmd_col(cmd_col), .cmd_ap(cmd_ap), .cmd_chop(cmd_chop),
    .cfg_cl(cfg_cl), .cfg_al(cfg_al), .dq_rise(dq_rise), .dq_fall(dq_fall),
    .dq_oe(dq_oe), .dqs_oe(dqs_oe), .dqs_pre(dqs_pre), .dqs_post(dqs_post),
    .spacing_err(spacing_err), .pre_req(pre_req), .pre_bank(pre_bank)
  );

  localparam int N = 4096;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit          e_oe [N];
  logic [15:0] e_r  [N];
  logic [15:0] e_f  [N];
  bit          e_err[N];
  bit          e_prq[N];
  logic [2:0]  e_pb [N];
  int last_acc = -100;
  int c_oe, c_pre, c_post, run, maxrun;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d act=%0h exp=%0h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [15:0] word(logic [2:0] b, logic [9:0] c, int j);
    logic [2:0] lo;
    lo = 3'(int'(c[2:0]) + j);
    return {3'b101, b, c[9:3], lo};
  endfunction

  task automatic observe();
    int t;
    bit xp, xq;
    t  = cyc;
    xp = !e_oe[t] && e_oe[t+1];
    xq = e_oe[t] && !e_oe[t+1];
    chk(dq_oe == e_oe[t], "R5 dq_oe", dq_oe, e_oe[t]);
    if (e_oe[t]) begin
      chk(dq_rise == e_r[t], "R2/R3 rise beat", dq_rise, e_r[t]);
      chk(dq_fall == e_f[t], "R2/R3 fall beat", dq_fall, e_f[t]);
    end
    chk(dqs_pre == xp, "R6 preamble", dqs_pre, xp);
    chk(dqs_post == xq, "R7 postamble", dqs_post, xq);
    chk(dqs_oe == (e_oe[t] || xp), "R12 strobe enable", dqs_oe, e_oe[t] || xp);
    chk(spacing_err == e_err[t], "R10 spacing_err", spacing_err, e_err[t]);
    chk(pre_req == e_prq[t], "R11 pre_req", pre_req, e_prq[t]);
    if (e_prq[t]) chk(pre_bank == e_pb[t], "R11 pre_bank", pre_bank, e_pb[t]);
    if (dq_oe) c_oe++;
    if (dqs_pre) c_pre++;
    if (dqs_post) c_post++;
    run = dq_oe ? run + 1 : 0;
    if (run > maxrun) maxrun = run;
  endtask

  task automatic step(bit rd, logic [2:0] b, logic [9:0] c, bit ap, bit chop);
    int t, rl, len;
    @(negedge clk);
    observe();
    t = cyc;
    cmd_rd = rd; cmd_bank = b; cmd_col = c; cmd_ap = ap; cmd_chop = chop;
    if (rd) begin
      if (t - last_acc >= 4) begin
        last_acc = t;
        rl  = int'(cfg_al) + int'(cfg_cl);
        len = chop ? 2 : 4;
        for (int j = 0; j < len; j++) begin
          e_oe[t+rl+j] = 1'b1;
          e_r[t+rl+j]  = word(b, c, 2*j);
          e_f[t+rl+j]  = word(b, c, 2*j+1);
        end
        if (ap) begin
          e_prq[t+rl+len] = 1'b1;
          e_pb[t+rl+len]  = b;
        end
      end else begin
        e_err[t+1] = 1'b1;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int idx;
    logic [2:0] b;
    // R1: reset state
    repeat (3) step(0, 0, 0, 0, 0);
    chk({dq_oe, dqs_oe, dqs_pre, dqs_post, spacing_err, pre_req} == 6'b0,
        "R1 reset flags", {dq_oe, dqs_oe, dqs_pre, dqs_post, spacing_err, pre_req}, 0);
    chk(dq_rise == 16'h0 && pre_bank == 3'd0, "R1 reset data", dq_rise, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idx = 0;
    for (int cl = 5; cl <= 11; cl++) begin
      for (int al = 0; al < cl; al++) begin
        cfg_cl = 4'(cl);
        cfg_al = 4'(al);
        b = 3'(idx);
        c_oe = 0; c_pre = 0; c_post = 0; run = 0; maxrun = 0;
        for (int s = 0; s < 44; s++) begin
          case (s)
            0:  step(1, b,        10'(idx*37),       1, 0);
            2:  step(1, b + 3'd4, 10'(idx*11),       1, 0);
            4:  step(1, b + 3'd1, 10'(idx*37 + 5),   0, 0);
            8:  step(1, b + 3'd2, 10'(idx*53 + 3),   1, 1);
            12: step(1, b + 3'd3, 10'(idx*29 + 7),   0, 1);
            14: step(1, b + 3'd5, 10'(idx*13),       1, 1);
            default: step(0, 0, 0, 0, 0);
          endcase
        end
        // R4: 4+4+2+2 data clocks in total
        chk(c_oe == 12, "R4 data clocks", c_oe, 12);
        // R8: first three bursts form one gapless run
        chk(maxrun == 10, "R8 seamless run", maxrun, 10);
        // R9: chopped gap framed by one extra postamble and preamble
        chk(c_pre == 2 && c_post == 2, "R9 chop gap framing", {c_pre, c_post}, {32'd2, 32'd2});
        idx++;
      end
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule